// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a two-port storage array and decides which side may use a location when both sides point at it. Each port presents an address and an active-low enable. When both ports are enabled and their addresses are equal, the block gives the location to whichever port arrived first. The other port gets an active-low busy flag and an active-high write-inhibit, which the array uses to block that port's writes.

The decision is based on addresses alone. Two reads of the same location are also treated as contention, so the block has no read/write input. Ownership is held in a registered three-value state: free, left owns, or right owns. It stays put until the winning port moves to another address or drops its enable. If both ports create a match on the same clock edge, the left port wins.

All outputs are registered. They show the inputs sampled at the previous rising clock edge. The reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `dp_contention_arbiter`

## Requirements
- R1: While reset is held, and on the first cycles after its release with both enables high, busy_l_n and busy_r_n are 1 and inhibit_l and inhibit_r are 0.
- R2: Contention exists on a clock edge when addr_l equals addr_r and both ce_l_n and ce_r_n are 0. In that case exactly one port is flagged: its busy is 0 and its inhibit is 1. The other port's busy is 1 and its inhibit is 0.
- R3: If the left port was unchanged since the previous edge and the right port's address or enable change creates contention, the right port is flagged.
- R4: If the right port was unchanged since the previous edge and the left port's address or enable change creates contention, the left port is flagged.
- R5: If both ports changed on the edge that creates contention, the right port is flagged.
- R6: Once a port is flagged, it stays flagged for as long as contention persists, whatever changes the winner makes that keep the match.
- R7: When the winner raises its enable or moves to a non-matching address, both flags clear on the next edge. If the winner later returns to the match while the loser stays unchanged, the former winner is now flagged.
- R8: A port whose enable was 1 at the previous edge shows busy 1 and inhibit 0.
- R9: If one port moves onto the other's old address on the same edge that the other port moves away, neither port is flagged.
- R10: Every output reflects the inputs sampled at the preceding rising clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_l_n | input | 1 | Left port enable, active low |
| ce_r_n | input | 1 | Right port enable, active low |
| addr_l | input | ADDR_W | Left port address |
| addr_r | input | ADDR_W | Right port address |
| busy_l_n | output | 1 | Left port busy, active low |
| busy_r_n | output | 1 | Right port busy, active low |
| inhibit_l | output | 1 | Left port write block, active high |
| inhibit_r | output | 1 | Right port write block, active high |

## Verification
The bench builds the arbiter with ADDR_W = 3. With only eight locations, equal addresses turn up often in a long pseudo-random walk. That walk therefore visits every ownership transition many times: arrival by address, arrival by enable, simultaneous arrival, hold, and release by either cause. Directed sequences pin down the late-arriver rule from each side, the left-wins tie, re-entry by a former winner, and a swap of positions on the same edge.

// File: rtl/dpca_pkg.sv
package dpca_pkg;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;

endpackage

// File: rtl/dpca_rst_sync.sv
module dpca_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/dpca_history.sv
module dpca_history #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              moved
);

  logic [ADDR_W-1:0] addr_q;
  logic              ce_n_q;
  logic              capture;

  assign capture = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ce_n_q <= 1'b1;
    end else if (capture) begin
      addr_q <= addr;
      ce_n_q <= ce_n;
    end
  end

  assign moved = (addr != addr_q) || (ce_n != ce_n_q);

endmodule

// File: rtl/dpca_match.sv
module dpca_match #(
  parameter int ADDR_W = 10
) (
  input  logic              ce_l_n,
  input  logic              ce_r_n,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              hit
);

  logic [ADDR_W-1:0] bit_eq;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_eq
    assign bit_eq[i] = ~(addr_l[i] ^ addr_r[i]);
  end

  assign hit = (&bit_eq) & ~ce_l_n & ~ce_r_n;

endmodule

// File: rtl/dpca_owner.sv
module dpca_owner
  import dpca_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hit,
  input  logic   moved_l,
  input  logic   moved_r,
  output owner_t owner_nxt,
  output owner_t owner_q
);

  always_comb begin
    owner_nxt = owner_q;
    if (!hit) begin
      owner_nxt = OWN_NONE;
    end else if (owner_q == OWN_NONE) begin
      if (moved_l && !moved_r) owner_nxt = OWN_RIGHT;
      else                     owner_nxt = OWN_LEFT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner_q <= OWN_NONE;
    else        owner_q <= owner_nxt;
  end

  a_r6_hold_while_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != OWN_NONE) && hit |=> owner_q == $past(owner_q));

  a_r7_release_on_nohit: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> owner_q == OWN_NONE);

  a_r5_tie_goes_left: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONE) && hit && moved_l && moved_r |=> owner_q == OWN_LEFT);

  a_r3_late_right_loses: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_NONE) && hit && !moved_l && moved_r |=> owner_q == OWN_LEFT);

endmodule

// File: rtl/dp_contention_arbiter.sv
module dp_contention_arbiter
  import dpca_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_l_n,
  input  logic              ce_r_n,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [ADDR_W-1:0] addr_r,
  output logic              busy_l_n,
  output logic              busy_r_n,
  output logic              inhibit_l,
  output logic              inhibit_r
);

  logic   rst_i_n;
  logic   hit;
  logic   moved_l;
  logic   moved_r;
  owner_t owner_nxt;
  owner_t owner_q;
  logic   busy_l_d, busy_r_d, inh_l_d, inh_r_d;

  dpca_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  dpca_match #(.ADDR_W(ADDR_W)) u_match (
    .ce_l_n(ce_l_n), .ce_r_n(ce_r_n),
    .addr_l(addr_l), .addr_r(addr_r), .hit(hit)
  );

  dpca_history #(.ADDR_W(ADDR_W)) u_hist_l (
    .clk(clk), .rst_n(rst_i_n), .ce_n(ce_l_n), .addr(addr_l), .moved(moved_l)
  );

  dpca_history #(.ADDR_W(ADDR_W)) u_hist_r (
    .clk(clk), .rst_n(rst_i_n), .ce_n(ce_r_n), .addr(addr_r), .moved(moved_r)
  );

  dpca_owner u_owner (
    .clk(clk), .rst_n(rst_i_n), .hit(hit),
    .moved_l(moved_l), .moved_r(moved_r),
    .owner_nxt(owner_nxt), .owner_q(owner_q)
  );

  always_comb begin
    inh_l_d  = (owner_nxt == OWN_RIGHT);
    inh_r_d  = (owner_nxt == OWN_LEFT);
    busy_l_d = ~(inh_l_d & ~ce_l_n);
    busy_r_d = ~(inh_r_d & ~ce_r_n);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      busy_l_n  <= 1'b1;
      busy_r_n  <= 1'b1;
      inhibit_l <= 1'b0;
      inhibit_r <= 1'b0;
    end else begin
      busy_l_n  <= busy_l_d;
      busy_r_n  <= busy_r_d;
      inhibit_l <= inh_l_d;
      inhibit_r <= inh_r_d;
    end
  end

  a_r2_never_both_busy: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(!busy_l_n && !busy_r_n));

  a_r8_idle_left_not_busy: assert property (@(posedge clk) disable iff (!rst_i_n)
    ce_l_n |=> busy_l_n && !inhibit_l);

  a_r8_idle_right_not_busy: assert property (@(posedge clk) disable iff (!rst_i_n)
    ce_r_n |=> busy_r_n && !inhibit_r);

  a_r2_contention_flags_one: assert property (@(posedge clk) disable iff (!rst_i_n)
    hit |=> (inhibit_l ^ inhibit_r));

endmodule

// File: tb/dp_contention_arbiter_test.sv
module dp_contention_arbiter_test;

  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_l_n, ce_r_n;
  logic [AW-1:0] addr_l, addr_r;
  logic          busy_l_n, busy_r_n, inhibit_l, inhibit_r;

  int checks = 0;
  int fails  = 0;

  int          m_own;
  logic [AW-1:0] p_al, p_ar;
  logic        p_cl, p_cr;
  logic [31:0] seed;

  always #2 clk = ~clk;

  dp_contention_arbiter #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_l_n(ce_l_n), .ce_r_n(ce_r_n),
    .addr_l(addr_l), .addr_r(addr_r),
    .busy_l_n(busy_l_n), .busy_r_n(busy_r_n),
    .inhibit_l(inhibit_l), .inhibit_r(inhibit_r)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {busy_l_n,busy_r_n,inh_l,inh_r} actual %b expected %b",
               tag, act, exp);
    end
  endtask

  function automatic logic [3:0] expected();
    logic bl, br, il, ir;
    il = (m_own == 2);
    ir = (m_own == 1);
    bl = ~il;
    br = ~ir;
    return {bl, br, il, ir};
  endfunction

  task automatic step(input logic [AW-1:0] al, input logic [AW-1:0] ar,
                      input logic cl, input logic cr, input string tag);
    logic hit, chl, chr;
    addr_l = al; addr_r = ar; ce_l_n = cl; ce_r_n = cr;
    hit = (al == ar) && !cl && !cr;
    chl = (al != p_al) || (cl != p_cl);
    chr = (ar != p_ar) || (cr != p_cr);
    if (!hit)            m_own = 0;
    else if (m_own == 0) m_own = (chl && !chr) ? 2 : 1;
    p_al = al; p_ar = ar; p_cl = cl; p_cr = cr;
    @(negedge clk);
    check(tag, {busy_l_n, busy_r_n, inhibit_l, inhibit_r}, expected());
  endtask

  initial begin
    #390000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_l_n = 1'b1; ce_r_n = 1'b1; addr_l = '0; addr_r = '0;
    m_own = 0; p_al = '0; p_ar = '0; p_cl = 1'b1; p_cr = 1'b1;
    seed = 32'h1234_5678;
    repeat (3) @(negedge clk);
    check("R1 in reset", {busy_l_n, busy_r_n, inhibit_l, inhibit_r}, 4'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {busy_l_n, busy_r_n, inhibit_l, inhibit_r}, 4'b1100);

    step(3'd1, 3'd2, 1'b0, 1'b0, "R10 distinct addresses");
    step(3'd1, 3'd1, 1'b0, 1'b0, "R3 right arrives late");
    step(3'd1, 3'd1, 1'b0, 1'b0, "R6 hold");
    step(3'd3, 3'd1, 1'b0, 1'b0, "R7 winner moves away");
    step(3'd2, 3'd3, 1'b0, 1'b0, "R10 setup");
    step(3'd3, 3'd3, 1'b0, 1'b0, "R4 left arrives late");
    step(3'd3, 3'd3, 1'b0, 1'b0, "R6 hold right owner");
    step(3'd3, 3'd3, 1'b0, 1'b1, "R7 winner raises enable");
    step(3'd3, 3'd3, 1'b0, 1'b0, "R7 former winner returns and loses");
    step(3'd5, 3'd6, 1'b0, 1'b0, "R10 setup tie");
    step(3'd4, 3'd4, 1'b0, 1'b0, "R5 simultaneous arrival");
    step(3'd1, 3'd2, 1'b0, 1'b0, "R10 setup swap");
    step(3'd2, 3'd3, 1'b0, 1'b0, "R9 move onto vacated address");
    step(3'd5, 3'd5, 1'b1, 1'b0, "R8 left deselected");
    step(3'd5, 3'd5, 1'b0, 1'b0, "R8 left enable arrives late");
    step(3'd5, 3'd5, 1'b1, 1'b0, "R8 loser deselects");

    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] na, nb;
      logic ca, cb;
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 17);
      seed = seed ^ (seed << 5);
      na = (seed[3:2] == 2'd0) ? seed[6:4] : p_al;
      nb = (seed[8:7] == 2'd0) ? seed[11:9] : p_ar;
      if (seed[12]) nb = na;
      ca = (seed[15:13] == 3'd0) ? ~p_cl : p_cl;
      cb = (seed[18:16] == 3'd0) ? ~p_cr : p_cr;
      step(na, nb, ca, cb, "R2 sweep");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule